// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block conditions the second operand of an integer ALU before the operation runs. A single combinational path takes a data word and a shift kind, with the amount coming either from a 5-bit immediate field or from an 8-bit register-supplied count. It returns the conditioned word together with a carry-out for the flag logic, and the result is ready in the same cycle as the operand, so the ALU can use it within the same instruction.

Four shift kinds are supported: logical left, logical right, arithmetic right and rotate right. A fifth operation, a one-place rotate through the carry flag, is reached by asking for a rotate with an immediate amount of zero. The carry-out is the last bit pushed out of the word. When nothing is shifted, the carry-out is the incoming flag. Register-supplied counts of one full word width or more follow fixed saturation rules. The block holds no state.

Top module: `opnd_shifter`

## Requirements
- R1: Kind code 00 is a logical left shift by n (1..31): the result is the input times 2^n modulo 2^32, with zeros in the low n bits, and the carry-out is input bit 32-n. A shift by 2 gives four times the input, and a shift by 1 added to the input gives three times the input.
- R2: Kind code 01 is a logical right shift by n (1..31): zeros enter the top n bits, and the carry-out is input bit n-1.
- R3: Kind code 10 is an arithmetic right shift by n (1..31): copies of input bit 31 enter the top n bits, and the carry-out is input bit n-1.
- R4: Kind code 11 with a non-zero amount is a rotate right: bits leaving bit 0 re-enter at bit 31, and the carry-out equals result bit 31. A register amount is taken modulo 32. A non-zero register amount that is a multiple of 32 returns the input unchanged, with carry-out equal to input bit 31.
- R5: Kind code 11 with the immediate source selected and an immediate amount of 0 rotates right by one through the carry. The result is {carry_in, input[31:1]} and the carry-out is input bit 0.
- R6: An amount of zero (an immediate 0 for kinds 00, 01 and 10, or a register amount of 0 for any kind) passes the input through unchanged, and the carry-out equals carry_in.
- R7: A register amount of exactly 32 gives a result of 0 with carry-out equal to input bit 0 for kind 00. It gives 0 with carry-out equal to input bit 31 for kind 01. For kind 10, every bit of the result and the carry-out equal input bit 31.
- R8: A register amount from 33 to 255 gives a result of 0 with carry-out 0 for kinds 00 and 01. For kind 10, every bit of the result and the carry-out equal input bit 31.
- R9: When amt_from_reg is 0, only amt_imm sets the amount and amt_reg has no effect. When amt_from_reg is 1, only amt_reg sets the amount and amt_imm has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_in | input | 32 | Operand to be conditioned |
| shift_kind | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| amt_imm | input | 5 | Immediate shift amount |
| amt_reg | input | 8 | Register-supplied shift amount (low byte) |
| amt_from_reg | input | 1 | 1 selects amt_reg, 0 selects amt_imm |
| carry_in | input | 1 | Current carry flag |
| opnd_out | output | 32 | Conditioned operand |
| carry_out | output | 1 | Last bit shifted out, or carry_in when nothing moves |

## Verification
The bench sweeps every kind against every immediate amount, and against register amounts from 0 through 40 plus several large counts. Each result and carry is compared with a model built from multiplication and division. Several slips are targeted. Off-by-one carry indexing would report the neighbour bit. Treating an immediate zero rotate as a plain rotate would lose the carry-through rotate. A shifter that wraps the register amount modulo 32 for logical kinds would return the input instead of zero at 32 and above. An arithmetic fill taken from a constant instead of bit 31 would break negative operands. The three-times and four-times identities, and the checks that the unused amount source has no effect, catch a swapped amount select.

// File: rtl/shf_pkg.sv
// Shared encodings for the operand shifter.
// Assumes a 2-bit kind field decoded by the instruction decoder upstream.
package shf_pkg;
    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/shf_amt_select.sv
// Amount selection: picks the immediate or register count and flags the two
// special cases (no movement, and the one-place rotate through carry).
// Assumes RAMT_W > AMT_W.
module shf_amt_select
    import shf_pkg::*;
#(
    parameter int AMT_W  = 5,
    parameter int RAMT_W = 8
) (
    input  logic [1:0]        kind,
    input  logic [AMT_W-1:0]  amt_imm,
    input  logic [RAMT_W-1:0] amt_reg,
    input  logic              use_reg,
    output logic [RAMT_W-1:0] amt,
    output logic              rrx,
    output logic              nop
);
    // Purpose: choose the amount source and classify the special cases.
    always_comb begin
        amt = use_reg ? amt_reg : RAMT_W'(amt_imm);
        rrx = !use_reg && (shift_kind_e'(kind) == SHK_ROR) && (amt_imm == '0);
        nop = (amt == '0) && !rrx;
    end
endmodule

// File: rtl/shf_rotr.sv
// Logarithmic right rotator: one stage per amount bit, each stage rotates
// by a power of two. Assumes DATA_W is a power of two equal to 2**AMT_W.
module shf_rotr #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  rot,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stg [0:AMT_W];

    assign stg[0] = din;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int DIST = 1 << s;
        // Purpose: rotate right by 2**s when this amount bit is set.
        assign stg[s+1] = rot[s] ? {stg[s][DIST-1:0], stg[s][DATA_W-1:DIST]}
                                 : stg[s];
    end

    assign dout = stg[AMT_W];
endmodule

// File: rtl/shf_fill_carry.sv
// Fill and carry stage: masks the rotated word into a logical or arithmetic
// shift, applies saturation for wide register amounts and picks the bit that
// leaves the word as the carry-out. Assumes the rotated input was rotated
// right by amt (right kinds) or by -amt (left kind), both modulo DATA_W.
module shf_fill_carry
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5,
    parameter int RAMT_W = 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rotd,
    input  logic [1:0]        kind,
    input  logic [RAMT_W-1:0] amt,
    input  logic              rrx,
    input  logic              nop,
    input  logic              cin,
    output logic [DATA_W-1:0] dout,
    output logic              cout
);
    localparam logic [DATA_W-1:0] ONES = '1;
    localparam logic [RAMT_W-1:0] WIDE = RAMT_W'(DATA_W);

    logic [AMT_W-1:0]  n_lo;
    logic [AMT_W-1:0]  idx_dn;
    logic [AMT_W-1:0]  idx_up;
    logic [DATA_W-1:0] keep_lo;
    logic [DATA_W-1:0] keep_hi;
    logic              sign;
    logic              big;
    logic              over;

    // Purpose: derive masks, carry indices and saturation flags from the amount.
    always_comb begin
        n_lo    = amt[AMT_W-1:0];
        idx_dn  = n_lo - AMT_W'(1);
        idx_up  = AMT_W'(0) - n_lo;
        keep_lo = ONES >> n_lo;
        keep_hi = ONES << n_lo;
        sign    = din[DATA_W-1];
        big     = amt >= WIDE;
        over    = amt > WIDE;
    end

    // Purpose: form the shifted word and carry for the selected kind.
    always_comb begin
        unique case (shift_kind_e'(kind))
            SHK_LSL: begin
                dout = big ? '0 : (rotd & keep_hi);
                cout = over ? 1'b0 : din[idx_up];
            end
            SHK_LSR: begin
                dout = big ? '0 : (rotd & keep_lo);
                cout = over ? 1'b0 : din[idx_dn];
            end
            SHK_ASR: begin
                dout = big ? {DATA_W{sign}}
                           : ((rotd & keep_lo) | ({DATA_W{sign}} & ~keep_lo));
                cout = big ? sign : din[idx_dn];
            end
            default: begin
                dout = rotd;
                cout = din[idx_dn];
            end
        endcase
        if (rrx) begin
            dout = {cin, din[DATA_W-1:1]};
            cout = din[0];
        end
        if (nop) begin
            dout = din;
            cout = cin;
        end
    end
endmodule

// File: rtl/opnd_shifter.sv
// Top of the second-operand barrel shifter. Purely combinational: selects
// the amount, rotates the operand, then masks and picks the carry-out.
// Assumes DATA_W is a power of two and RAMT_W can hold values above DATA_W.
module opnd_shifter
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RAMT_W = 8
) (
    input  logic [DATA_W-1:0]         opnd_in,
    input  logic [1:0]                shift_kind,
    input  logic [$clog2(DATA_W)-1:0] amt_imm,
    input  logic [RAMT_W-1:0]         amt_reg,
    input  logic                      amt_from_reg,
    input  logic                      carry_in,
    output logic [DATA_W-1:0]         opnd_out,
    output logic                      carry_out
);
    localparam int AMT_W = $clog2(DATA_W);

    logic [RAMT_W-1:0] amt;
    logic              is_rrx;
    logic              is_nop;
    logic [AMT_W-1:0]  rot_amt;
    logic [DATA_W-1:0] rotated;

    shf_amt_select #(.AMT_W(AMT_W), .RAMT_W(RAMT_W)) u_sel (
        .kind    (shift_kind),
        .amt_imm (amt_imm),
        .amt_reg (amt_reg),
        .use_reg (amt_from_reg),
        .amt     (amt),
        .rrx     (is_rrx),
        .nop     (is_nop)
    );

    // Purpose: a left shift is a right rotate by the complement amount.
    always_comb begin
        if (shift_kind_e'(shift_kind) == SHK_LSL)
            rot_amt = AMT_W'(0) - amt[AMT_W-1:0];
        else
            rot_amt = amt[AMT_W-1:0];
    end

    shf_rotr #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rot (
        .din  (opnd_in),
        .rot  (rot_amt),
        .dout (rotated)
    );

    shf_fill_carry #(.DATA_W(DATA_W), .AMT_W(AMT_W), .RAMT_W(RAMT_W)) u_fill (
        .din  (opnd_in),
        .rotd (rotated),
        .kind (shift_kind),
        .amt  (amt),
        .rrx  (is_rrx),
        .nop  (is_nop),
        .cin  (carry_in),
        .dout (opnd_out),
        .cout (carry_out)
    );
endmodule

// File: rtl/opnd_shifter_chk.sv
// Port-level checker for the operand shifter. The block has no clock, so the
// checks are immediate assertions evaluated whenever the ports settle, and
// skipped while any input is still unknown.
module opnd_shifter_chk #(
    parameter int DATA_W = 32,
    parameter int RAMT_W = 8
) (
    input logic [DATA_W-1:0]         opnd_in,
    input logic [1:0]                shift_kind,
    input logic [$clog2(DATA_W)-1:0] amt_imm,
    input logic [RAMT_W-1:0]         amt_reg,
    input logic                      amt_from_reg,
    input logic                      carry_in,
    input logic [DATA_W-1:0]         opnd_out,
    input logic                      carry_out
);
    localparam logic [DATA_W-1:0] ONES = '1;

    int  n;
    bit  rrx_case;
    bit  known;

    // Purpose: decode the effective amount independently and check the ports.
    always_comb begin
        known    = !$isunknown({opnd_in, shift_kind, amt_imm, amt_reg,
                                amt_from_reg, carry_in});
        n        = amt_from_reg ? int'(amt_reg) : int'(amt_imm);
        rrx_case = !amt_from_reg && shift_kind == 2'b11 && amt_imm == '0;
        if (known) begin
            if (n == 0 && !rrx_case)
                AST_ZERO_PASSES: assert (opnd_out == opnd_in && carry_out == carry_in)
                    else $error("zero amount altered data"); // R6
            if (rrx_case)
                AST_RRX_CARRY_PATH: assert (carry_out == opnd_in[0] && opnd_out[DATA_W-1] == carry_in)
                    else $error("carry rotate wrong"); // R5
            if (shift_kind == 2'b00 && n > 0 && n < DATA_W)
                AST_LSL_LOW_ZERO: assert ((opnd_out & ~(ONES << n)) == '0)
                    else $error("left shift fill"); // R1
            if (shift_kind == 2'b01 && n > 0 && n < DATA_W)
                AST_LSR_HIGH_ZERO: assert ((opnd_out & ~(ONES >> n)) == '0)
                    else $error("right shift fill"); // R2
            if (shift_kind == 2'b10)
                AST_ASR_SIGN_KEPT: assert (opnd_out[DATA_W-1] == opnd_in[DATA_W-1])
                    else $error("arith sign lost"); // R3
            if (shift_kind == 2'b11 && n != 0)
                AST_ROR_BITS_KEPT: assert ($countones(opnd_out) == $countones(opnd_in)
                                           && carry_out == opnd_out[DATA_W-1])
                    else $error("rotate lost bits"); // R4
            if (shift_kind[1] == 1'b0 && n > DATA_W)
                AST_WIDE_LOGICAL_ZERO: assert (opnd_out == '0 && carry_out == 1'b0)
                    else $error("wide logical shift"); // R8
            if (shift_kind == 2'b10 && n >= DATA_W)
                AST_WIDE_ASR_FILL: assert (opnd_out == {DATA_W{opnd_in[DATA_W-1]}}
                                           && carry_out == opnd_in[DATA_W-1])
                    else $error("wide arith shift"); // R7
        end
    end
endmodule

bind opnd_shifter opnd_shifter_chk #(.DATA_W(DATA_W), .RAMT_W(RAMT_W)) u_chk (
    .opnd_in      (opnd_in),
    .shift_kind   (shift_kind),
    .amt_imm      (amt_imm),
    .amt_reg      (amt_reg),
    .amt_from_reg (amt_from_reg),
    .carry_in     (carry_in),
    .opnd_out     (opnd_out),
    .carry_out    (carry_out)
);

// File: tb/opnd_shifter_test.sv
`timescale 1ns/1ps
// Exhaustive-amount bench for the operand shifter, with an arithmetic model.
module opnd_shifter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_in = '0;
    logic [1:0]  shift_kind = '0;
    logic [4:0]  amt_imm = '0;
    logic [7:0]  amt_reg = '0;
    logic        amt_from_reg = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] opnd_out;
    logic        carry_out;

    int n_cmp = 0;
    int n_bad = 0;

    opnd_shifter uut (
        .opnd_in      (opnd_in),
        .shift_kind   (shift_kind),
        .amt_imm      (amt_imm),
        .amt_reg      (amt_reg),
        .amt_from_reg (amt_from_reg),
        .carry_in     (carry_in),
        .opnd_out     (opnd_out),
        .carry_out    (carry_out)
    );

    always #2.5 clk = ~clk;

    logic [31:0] pats [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000,
                              32'h0000_0001, 32'hA5C3_0F96, 32'h7FFF_FFFF,
                              32'h1234_5678, 32'h8000_0001};

    function automatic longint unsigned pw(input int k);
        return 64'd1 << k;
    endfunction

    // Arithmetic model: returns {carry, result}.
    function automatic logic [32:0] model(input int kind, input int n, input bit rrx,
                                          input logic [31:0] a, input bit c);
        longint unsigned av = 64'(a);
        longint unsigned full = 64'hFFFF_FFFF;
        longint unsigned r;
        longint unsigned p;
        longint unsigned inv;
        bit co;
        int nn;
        int m;
        if (rrx) begin
            r = (c ? 64'h8000_0000 : 64'd0) + av / 2; co = bit'(av % 2);
        end else if (n == 0) begin
            r = av; co = c;
        end else begin
            case (kind)
                0: if (n > 32) begin r = 0; co = 0; end
                   else begin p = av * pw(n); r = p % pw(32); co = bit'((p / pw(32)) % 2); end
                1: if (n > 32) begin r = 0; co = 0; end
                   else begin r = av / pw(n); co = bit'((av / pw(n-1)) % 2); end
                2: begin
                    nn = (n > 32) ? 32 : n;
                    if (av < pw(31)) begin
                        r = av / pw(nn); co = bit'((av / pw(nn-1)) % 2);
                    end else begin
                        inv = full - av;
                        r = full - inv / pw(nn);
                        co = !bit'((inv / pw(nn-1)) % 2);
                    end
                end
                default: begin
                    m = n % 32;
                    if (m == 0) r = av;
                    else r = (av / pw(m) + av * pw(32 - m)) % pw(32);
                    co = bit'(r / pw(31));
                end
            endcase
        end
        return {co, r[31:0]};
    endfunction

    function automatic string req_of(input int kind, input int n, input bit rrx);
        if (rrx) return "R5";
        if (n == 0) return "R6";
        if (kind != 3 && n == 32) return "R7";
        if (kind != 3 && n > 32) return "R8";
        case (kind)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic apply(input int kind, input int imm, input int rg, input bit use_rg,
                         input logic [31:0] a, input bit c);
        @(negedge clk);
        shift_kind   = 2'(kind);
        amt_imm      = 5'(imm);
        amt_reg      = 8'(rg);
        amt_from_reg = use_rg;
        opnd_in      = a;
        carry_in     = c;
        #1;
    endtask

    task automatic compare(input string tag, input logic [32:0] exp);
        n_cmp++;
        if ({carry_out, opnd_out} !== exp) begin
            n_bad++;
            $display("FAIL %s kind=%0d imm=%0d reg=%0d src=%0b in=%h cin=%0b: got c=%0b d=%h exp c=%0b d=%h",
                     tag, shift_kind, amt_imm, amt_reg, amt_from_reg, opnd_in, carry_in,
                     carry_out, opnd_out, exp[32], exp[31:0]);
        end
    endtask

    task automatic run_case(input int kind, input int imm, input int rg, input bit use_rg,
                            input logic [31:0] a, input bit c);
        int  n = use_rg ? rg : imm;
        bit  rrx = !use_rg && kind == 3 && imm == 0;
        apply(kind, imm, rg, use_rg, a, c);
        compare(req_of(kind, n, rrx), model(kind, n, rrx, a, c));
    endtask

    logic [31:0] hold_a;
    logic [32:0] first;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R6: quiet inputs give a quiet output.
        apply(0, 0, 0, 0, 32'h0, 0);
        compare("R6", 33'h0);

        // R1: arithmetic identities of the left shift.
        hold_a = 32'h0000_1357;
        apply(0, 2, 0, 0, hold_a, 0);
        compare("R1", {1'b0, hold_a * 32'd4});
        apply(0, 1, 0, 0, hold_a, 0);
        n_cmp++;
        if (opnd_out + hold_a !== hold_a * 32'd3) begin
            n_bad++;
            $display("FAIL R1 triple: got %h exp %h", opnd_out + hold_a, hold_a * 32'd3);
        end

        // R9: the unselected amount source has no effect.
        apply(1, 4, 0, 0, 32'hF0F0_1234, 1);
        first = {carry_out, opnd_out};
        apply(1, 4, 255, 0, 32'hF0F0_1234, 1);
        compare("R9", first);
        compare("R9", model(1, 4, 0, 32'hF0F0_1234, 1));
        apply(2, 0, 8, 1, 32'h8765_4321, 0);
        first = {carry_out, opnd_out};
        apply(2, 31, 8, 1, 32'h8765_4321, 0);
        compare("R9", first);
        compare("R9", model(2, 8, 0, 32'h8765_4321, 0));
        apply(3, 0, 1, 1, 32'h0000_0003, 0);
        compare("R9", model(3, 1, 0, 32'h0000_0003, 0));

        // R1..R6: every kind against every immediate amount.
        for (int k = 0; k < 4; k++)
            for (int s = 0; s < 32; s++)
                for (int p = 0; p < 8; p++)
                    for (int c = 0; c < 2; c++)
                        run_case(k, s, 8'hC7, 0, pats[p], bit'(c));

        // R4, R6, R7, R8: register amounts including the wide range.
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 48; i++) begin
                int rg;
                if (i <= 40) rg = i;
                else case (i)
                    41: rg = 63; 42: rg = 64; 43: rg = 96; 44: rg = 128;
                    45: rg = 160; 46: rg = 200; default: rg = 255;
                endcase
                for (int p = 0; p < 8; p++)
                    for (int c = 0; c < 2; c++)
                        run_case(k, 13, rg, 1, pats[p], bit'(c));
            end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule